// File: doc/BRIEF.md
# Fully Associative Translation Cache with Tree Replacement

This block caches recent address translations for a processor core. Instruction fetch and data access share it. A lookup presents a virtual page number and an address-space tag. In the same cycle, without any register on the path, the block answers with a hit flag, the physical page number, the permission bits and the slot that matched. A fill installs a new translation into the slot chosen by a binary pseudo-LRU tree. The slot is written on the clock edge that ends the fill cycle.

A flush empties the whole structure in one cycle. It clears every valid bit and also returns every tree node to zero. This matters for isolation between software domains: leftover replacement history can leak timing information even when no entry is valid. Every fill goes to the tree's victim, so the tree state decides where each new translation lands. The lookup slot output lets that placement be seen at the ports. Page-table walking and permission enforcement belong to the surrounding logic.

Top module: `fa_tlb`

## Requirements
- R1: Out of reset, no lookup hits, and the first fill lands in slot 0.
- R2: While `lk_req_i` is high and `flush_i` is low, `lk_hit_o` rises in the same cycle when a valid slot holds both the presented page number and the presented address-space tag. A different tag is a miss. On a hit, `lk_ppn_o`, `lk_perm_o` and `lk_slot_o` give that slot's contents and index. On a miss, all three read zero.
- R3: A fill with `flush_i` low writes its slot on the clock edge. A lookup of the same key in the next cycle hits.
- R4: The tree has ENTRIES-1 node bits, stored heap-ordered: node n has children 2n+1 and 2n+2. A node value of 0 steers toward the lower half and 1 toward the upper half. The victim is the leaf reached by following the nodes from the root. Each use sets the nodes on its path to point away from the used slot. From the all-zero tree, successive fills therefore land in slots 0, 8, 4, 12, 2 and onward.
- R5: A lookup hit counts as a use of the matching slot. When a hit and a fill fall in the same cycle, the fill takes the victim of the tree as it stood before that cycle. The fill's path update is applied after the hit's update.
- R6: A flush clears every valid bit in one cycle, so every lookup in the following cycle misses.
- R7: A flush sets every tree node to 0, so the next fill lands in slot 0.
- R8: A lookup in the flush cycle reports a miss and does not touch the tree. A fill in the flush cycle is dropped.
- R9: With `lk_req_i` low, `lk_hit_o` stays low and the tree is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear all slots and the replacement tree |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_space_i | input | SPACE_W | Lookup address-space tag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | log2(ENTRIES) | Index of the hitting slot |
| lk_ppn_o | output | PPN_W | Physical page number of the hit |
| lk_perm_o | output | PERM_W | Permission bits of the hit |
| fill_en_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Virtual page number to install |
| fill_space_i | input | SPACE_W | Address-space tag to install |
| fill_ppn_i | input | PPN_W | Physical page number to install |
| fill_perm_i | input | PERM_W | Permission bits to install |

## Verification
Two pairs of functions can meet in one cycle. The first is a flush together with a lookup and a fill. The second is a lookup hit together with a fill, where both update the tree. Directed cycles drive a flush alongside a hit on a live key and a fill of a new key. The bench then judges the outcome from the next cycles: the hit must read as a miss, the fill must be absent, and the next fill must land in slot 0. The hit-with-fill case is driven directly, and the random phase also raises a flush, fill and lookup freely in the same cycle. A bench model applies the hit's path update before the fill's. Every later lookup's slot and data are then compared against that model.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;
    parameter int unsigned TLB_ENTRIES = 16;
    parameter int unsigned TLB_VPN_W   = 27;
    parameter int unsigned TLB_SPACE_W = 16;
    parameter int unsigned TLB_PPN_W   = 44;
    parameter int unsigned TLB_PERM_W  = 8;
endpackage

// File: rtl/fa_tlb_store.sv
module fa_tlb_store #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned VPN_W   = 27,
    parameter int unsigned SPACE_W = 16,
    parameter int unsigned PPN_W   = 44,
    parameter int unsigned PERM_W  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   widx_i,
    input  logic [VPN_W-1:0]   wvpn_i,
    input  logic [SPACE_W-1:0] wspace_i,
    input  logic [PPN_W-1:0]   wppn_i,
    input  logic [PERM_W-1:0]  wperm_i,
    input  logic [VPN_W-1:0]   cvpn_i,
    input  logic [SPACE_W-1:0] cspace_i,
    output logic [ENTRIES-1:0] match_o,
    input  logic [IDX_W-1:0]   ridx_i,
    output logic [PPN_W-1:0]   rppn_o,
    output logic [PERM_W-1:0]  rperm_o
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [SPACE_W-1:0] space_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q   [ENTRIES];
    logic [PERM_W-1:0]  perm_q  [ENTRIES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
        end else if (clear_i) begin
            valid_q <= '0;
        end else if (we_i) begin
            valid_q[widx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            vpn_q[widx_i]   <= wvpn_i;
            space_q[widx_i] <= wspace_i;
            ppn_q[widx_i]   <= wppn_i;
            perm_q[widx_i]  <= wperm_i;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match_o[i] = valid_q[i] && (vpn_q[i] == cvpn_i) && (space_q[i] == cspace_i);
    end

    assign rppn_o  = ppn_q[ridx_i];
    assign rperm_o = perm_q[ridx_i];
endmodule

// File: rtl/fa_tlb_pick.sv
module fa_tlb_pick #(
    parameter int unsigned N     = 16,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/fa_tlb_plru.sv
module fa_tlb_plru #(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned NODES  = ENTRIES - 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             hit_en_i,
    input  logic [IDX_W-1:0] hit_idx_i,
    input  logic             fill_en_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    output logic [IDX_W-1:0] victim_o
);
    logic [NODES-1:0] tree_q;
    logic [NODES-1:0] after_hit;
    logic [NODES-1:0] tree_d;
    logic [ENTRIES-1:0] leaf_sel;

    // Per-node path update: hit first, fill applied on top.
    for (genvar j = 0; j < NODES; j++) begin : g_node
        localparam int unsigned LV  = $clog2(j + 2) - 1;
        localparam int unsigned POS = j + 1 - (1 << LV);
        logic on_hit;
        logic on_fill;
        assign on_hit  = (hit_idx_i  >> (IDX_W - LV)) == IDX_W'(POS);
        assign on_fill = (fill_idx_i >> (IDX_W - LV)) == IDX_W'(POS);
        assign after_hit[j] = (hit_en_i && on_hit) ? ~hit_idx_i[IDX_W-1-LV] : tree_q[j];
        assign tree_d[j]    = (fill_en_i && on_fill) ? ~fill_idx_i[IDX_W-1-LV] : after_hit[j];
    end

    // A leaf is the victim when every node on its path points to it.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_leaf
        logic [IDX_W-1:0] path_ok;
        for (genvar lv = 0; lv < IDX_W; lv++) begin : g_lvl
            localparam int unsigned NODE = (1 << lv) - 1 + (k >> (IDX_W - lv));
            localparam int unsigned DIR  = (k >> (IDX_W - 1 - lv)) & 1;
            assign path_ok[lv] = tree_q[NODE] == 1'(DIR);
        end
        assign leaf_sel[k] = &path_ok;
    end

    always_comb begin
        victim_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (leaf_sel[i]) begin
                victim_o = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tree_q <= '0;
        end else if (clear_i) begin
            tree_q <= '0;
        end else begin
            tree_q <= tree_d;
        end
    end
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import fa_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    parameter int unsigned VPN_W   = TLB_VPN_W,
    parameter int unsigned SPACE_W = TLB_SPACE_W,
    parameter int unsigned PPN_W   = TLB_PPN_W,
    parameter int unsigned PERM_W  = TLB_PERM_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               flush_i,
    input  logic               lk_req_i,
    input  logic [VPN_W-1:0]   lk_vpn_i,
    input  logic [SPACE_W-1:0] lk_space_i,
    output logic               lk_hit_o,
    output logic [IDX_W-1:0]   lk_slot_o,
    output logic [PPN_W-1:0]   lk_ppn_o,
    output logic [PERM_W-1:0]  lk_perm_o,
    input  logic               fill_en_i,
    input  logic [VPN_W-1:0]   fill_vpn_i,
    input  logic [SPACE_W-1:0] fill_space_i,
    input  logic [PPN_W-1:0]   fill_ppn_i,
    input  logic [PERM_W-1:0]  fill_perm_i
);
    logic [ENTRIES-1:0] match;
    logic               any_match;
    logic [IDX_W-1:0]   match_idx;
    logic [IDX_W-1:0]   fill_slot;
    logic [PPN_W-1:0]   rd_ppn;
    logic [PERM_W-1:0]  rd_perm;
    logic               hit;
    logic               fill_fire;

    assign fill_fire = fill_en_i && !flush_i;

    fa_tlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPACE_W(SPACE_W),
        .PPN_W(PPN_W), .PERM_W(PERM_W)
    ) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (flush_i),
        .we_i     (fill_fire),
        .widx_i   (fill_slot),
        .wvpn_i   (fill_vpn_i),
        .wspace_i (fill_space_i),
        .wppn_i   (fill_ppn_i),
        .wperm_i  (fill_perm_i),
        .cvpn_i   (lk_vpn_i),
        .cspace_i (lk_space_i),
        .match_o  (match),
        .ridx_i   (match_idx),
        .rppn_o   (rd_ppn),
        .rperm_o  (rd_perm)
    );

    fa_tlb_pick #(.N(ENTRIES)) u_hitpick (
        .vec_i (match),
        .any_o (any_match),
        .idx_o (match_idx)
    );

    assign hit = lk_req_i && !flush_i && any_match;

    fa_tlb_plru #(.ENTRIES(ENTRIES)) u_plru (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (flush_i),
        .hit_en_i   (hit),
        .hit_idx_i  (match_idx),
        .fill_en_i  (fill_fire),
        .fill_idx_i (fill_slot),
        .victim_o   (fill_slot)
    );

    assign lk_hit_o  = hit;
    assign lk_slot_o = hit ? match_idx : '0;
    assign lk_ppn_o  = hit ? rd_ppn : '0;
    assign lk_perm_o = hit ? rd_perm : '0;
endmodule

// File: rtl/fa_tlb_chk.sv
module fa_tlb_chk #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned VPN_W   = 27,
    parameter int unsigned SPACE_W = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               flush_i,
    input logic               lk_req_i,
    input logic [VPN_W-1:0]   lk_vpn_i,
    input logic [SPACE_W-1:0] lk_space_i,
    input logic               lk_hit_o,
    input logic               fill_en_i,
    input logic [VPN_W-1:0]   fill_vpn_i,
    input logic [SPACE_W-1:0] fill_space_i,
    input logic [IDX_W-1:0]   victim_i
);
    // R8: lookups in a flush cycle miss
    a_r8_flush_cycle_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !lk_hit_o);

    // R6: the cycle after a flush holds no valid slot
    a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !lk_hit_o);

    // R7: the tree is back at zero after a flush
    a_r7_tree_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (victim_i == '0));

    // R9: no request, no hit
    a_r9_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_req_i |-> !lk_hit_o);

    // R3: a filled key is found in the next cycle
    a_r3_fill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_en_i && !flush_i) |=>
            (!(lk_req_i && !flush_i && lk_vpn_i == $past(fill_vpn_i)
               && lk_space_i == $past(fill_space_i)) || lk_hit_o));

    // R4: a fill moves the victim away from the slot it used
    a_r4_victim_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_en_i && !flush_i) |=> (victim_i != $past(victim_i)));
endmodule

bind fa_tlb fa_tlb_chk #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .SPACE_W(SPACE_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .lk_req_i     (lk_req_i),
    .lk_vpn_i     (lk_vpn_i),
    .lk_space_i   (lk_space_i),
    .lk_hit_o     (lk_hit_o),
    .fill_en_i    (fill_en_i),
    .fill_vpn_i   (fill_vpn_i),
    .fill_space_i (fill_space_i),
    .victim_i     (fill_slot)
);

// File: tb/fa_tlb_test.sv
module fa_tlb_test;
    localparam int N  = 16;
    localparam int LG = 4;
    localparam int VW = 27;
    localparam int SW = 16;
    localparam int PW = 44;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          lk_req = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [SW-1:0] lk_space = '0;
    logic          lk_hit;
    logic [LG-1:0] lk_slot;
    logic [PW-1:0] lk_ppn;
    logic [MW-1:0] lk_perm;
    logic          fill_en = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [SW-1:0] fill_space = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic [MW-1:0] fill_perm = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int key_ctr = 1;

    // bench model
    bit            m_valid [N];
    logic [VW-1:0] m_vpn   [N];
    logic [SW-1:0] m_space [N];
    logic [PW-1:0] m_ppn   [N];
    logic [MW-1:0] m_perm  [N];
    bit            m_tree  [N-1];

    always #4 clk = ~clk;

    fa_tlb uut (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_space_i(lk_space),
        .lk_hit_o(lk_hit), .lk_slot_o(lk_slot), .lk_ppn_o(lk_ppn), .lk_perm_o(lk_perm),
        .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_space_i(fill_space),
        .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm)
    );

    function automatic int m_victim();
        int n = 0;
        for (int l = 0; l < LG; l++) n = 2 * n + 1 + int'(m_tree[n]);
        return n - (N - 1);
    endfunction

    function automatic void m_touch(int idx);
        int n = 0;
        for (int l = 0; l < LG; l++) begin
            int d = (idx >> (LG - 1 - l)) & 1;
            m_tree[n] = (d == 0);
            n = 2 * n + 1 + d;
        end
    endfunction

    function automatic int m_find(logic [VW-1:0] v, logic [SW-1:0] s);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == v && m_space[i] == s) return i;
        return -1;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        for (int i = 0; i < N - 1; i++) m_tree[i] = 1'b0;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; lk_req = 0; fill_en = 0;
    endtask

    task automatic set_lk(logic [VW-1:0] v, logic [SW-1:0] s);
        lk_req = 1; lk_vpn = v; lk_space = s;
    endtask

    task automatic set_fill();
        fill_en = 1;
        fill_vpn = VW'(key_ctr);
        key_ctr++;
        fill_space = SW'($urandom % 4);
        fill_ppn = {12'($urandom), $urandom};
        fill_perm = MW'($urandom);
    endtask

    // Inputs are set just after a falling edge; outputs are sampled 2 ns before the rising edge.
    task automatic tick(string tag, bit do_chk);
        int e;
        int h;
        int v;
        #2;
        e = (lk_req && !flush) ? m_find(lk_vpn, lk_space) : -1;
        if (do_chk) begin
            chk(tag, "hit", longint'(lk_hit), longint'(e >= 0));
            if (e >= 0) begin
                chk(tag, "slot", longint'(lk_slot), longint'(e));
                chk(tag, "ppn", longint'(lk_ppn), longint'(m_ppn[e]));
                chk(tag, "perm", longint'(lk_perm), longint'(m_perm[e]));
            end else begin
                chk(tag, "ppn on miss", longint'(lk_ppn), 0);
            end
        end
        if (flush) begin
            m_clear();
        end else begin
            v = m_victim();
            h = e;
            if (h >= 0) m_touch(h);
            if (fill_en) begin
                m_valid[v] = 1'b1;
                m_vpn[v] = fill_vpn;
                m_space[v] = fill_space;
                m_ppn[v] = fill_ppn;
                m_perm[v] = fill_perm;
                m_touch(v);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [VW-1:0] kv;
        logic [SW-1:0] ks;
        void'($urandom(32'd2024));
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: nothing hits out of reset
        set_lk(VW'(5), SW'(0));
        tick("R1", 1);
        idle();

        // R1: first fill goes to slot 0
        set_fill();
        kv = fill_vpn; ks = fill_space;
        tick("R1", 0);
        idle();
        set_lk(kv, ks);
        #2;
        chk("R1", "first slot", longint'(lk_slot), 0);
        chk("R3", "fill visible", longint'(lk_hit), 1);
        #6;
        idle();

        // R4: fill the rest, each checked by lookup of the newest key next cycle
        for (int i = 1; i < N; i++) begin
            set_fill();
            kv = fill_vpn; ks = fill_space;
            tick("R4", 0);
            idle();
            set_lk(kv, ks);
            #2;
            chk("R4", "fill order slot", longint'(lk_slot),
                longint'({i[0], i[1], i[2], i[3]}));
            #6;
            idle();
        end

        // R2: tag mismatch misses, matching key hits
        set_lk(m_vpn[3], m_space[3] + SW'(1));
        tick("R2", 1);
        set_lk(m_vpn[3], m_space[3]);
        tick("R2", 1);

        // R9: no request means no hit and no tree update
        lk_req = 0; lk_vpn = m_vpn[7]; lk_space = m_space[7];
        #2;
        chk("R9", "hit without req", longint'(lk_hit), 0);
        #6;
        idle();

        // R5: hit and fill in the same cycle
        set_lk(m_vpn[m_victim()], m_space[m_victim()]);
        set_fill();
        tick("R5", 1);
        idle();
        for (int i = 0; i < 3; i++) begin
            set_fill();
            tick("R5", 0);
            idle();
        end
        for (int i = 0; i < N; i++) begin
            set_lk(m_vpn[i], m_space[i]);
            tick("R5", 1);
        end
        idle();

        // R8: flush together with a live lookup and a fill
        set_lk(m_vpn[2], m_space[2]);
        #2;
        chk("R8", "pre-flush hit", longint'(lk_hit), 1);
        #6;
        flush = 1;
        set_fill();
        kv = fill_vpn; ks = fill_space;
        #2;
        chk("R8", "hit in flush cycle", longint'(lk_hit), 0);
        #6;
        idle();
        m_clear();
        // R6: everything misses next cycle
        set_lk(m_vpn[2], m_space[2]);
        #2;
        chk("R6", "hit after flush", longint'(lk_hit), 0);
        #6;
        set_lk(kv, ks);
        #2;
        chk("R8", "dropped fill", longint'(lk_hit), 0);
        #6;
        idle();

        // R7: next fill lands in slot 0
        set_fill();
        kv = fill_vpn; ks = fill_space;
        tick("R7", 0);
        idle();
        set_lk(kv, ks);
        #2;
        chk("R7", "slot after flush", longint'(lk_slot), 0);
        #6;
        idle();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            int r;
            int i;
            idle();
            flush = (($urandom % 50) == 0);
            if (($urandom % 10) < 3) set_fill();
            if (($urandom % 10) < 7) begin
                r = $urandom % 4;
                i = $urandom % N;
                if (r < 2 && m_valid[i]) set_lk(m_vpn[i], m_space[i]);
                else if (r == 3 && m_valid[i]) set_lk(m_vpn[i], m_space[i] ^ SW'(1));
                else set_lk(VW'(27'h7FF0000 + ($urandom % 256)), SW'($urandom % 4));
            end
            tick("R2", 1);
        end
        idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule